// File: doc/BRIEF.md
# Configurable GPIO Port Bank

This block holds a bank of general-purpose I/O ports. Each port has an output latch and a direction register of the same width. A processor-style command port reads, writes, sets or clears single bits in, or complements, either register. The block drives the pad output-enable and output-data lines. It samples the pad inputs through a two-flop synchroniser before using them.

Reads are registered. A read of a data register returns a mix, bit by bit. Where the direction bit is 1 the bit is an input, and the read returns the synchronised pad level. Where the direction bit is 0 the read returns the latch. The set, clear and complement commands build their result from that same mixed view and write it back into the latch. As a result, input bits pick up the current pad level in their latch. One port, chosen by parameter, raises a wake request while the bank is asleep. The request is raised when any of its input bits moves away from the level captured at the moment sleep began. Two bits of another port can be handed to a pair of PWM signals.

The command port never stalls. Every strobe is accepted in the cycle it is presented, so the port has no ready signal and applies no back-pressure. A read answer appears with a one-cycle valid pulse on the following cycle.

Top module: `gpio_bank`

## Requirements
- R1: After reset every direction bit is 1, so every pad_oe bit is 0, and every output latch holds 1.
- R2: pad_oe for each bit is the inverse of its direction bit. A direction bit of 0 drives the pad.
- R3: A read of a data register (address = 2*port) returns the synchronised pad level for bits whose direction bit is 1, and the latch for bits whose direction bit is 0. A read of a direction register (address = 2*port+1) returns the direction bits.
- R4: The latch, and so pad_out outside PWM bits, changes only on a command that modifies that data register. A write (cpu_op = 1) stores cpu_wdata even for input bits.
- R5: A pad level applied before clock edge n is first returned by a read captured at edge n+2. A read captured at edge n+1 still returns the older level.
- R6: Set (cpu_op = 2) and clear (cpu_op = 3) change bit cpu_bit of the read view and write the whole view back. Input bits of a data register therefore take the pad level into their latch.
- R7: Complement (cpu_op = 4) writes the inverted read view back to the addressed register.
- R8: The write, set, clear and complement commands act on a direction register in the same way, using the direction bits as the view.
- R9: Commands addressing a port index at or above the port count, and cpu_op codes 5 to 7, change no register. A read of such an address returns 0.
- R10: While sleep is high, wake rises one edge after the synchronised wake-port inputs differ from the levels held when sleep went high. Bits configured as outputs are ignored, and wake is 0 one edge after sleep is low.
- R11: While pwm_en is 1, pad_out bits PWM_LO and PWM_HI of port PWM_PORT follow pwm_in[0] and pwm_in[1], without altering the latch that a read returns.
- R12: A read (cpu_op = 0) produces cpu_rvalid high for exactly the following cycle, with cpu_rdata valid and held until the next read. No other command raises cpu_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_en | input | 1 | Command strobe, one command per cycle |
| cpu_op | input | 3 | 0 read, 1 write, 2 set bit, 3 clear bit, 4 complement |
| cpu_addr | input | ADDR_W | Port index in upper bits, bit 0 selects direction register |
| cpu_bit | input | BIT_W | Bit index for set and clear |
| cpu_wdata | input | PORT_W | Write data |
| cpu_rdata | output | PORT_W | Registered read data |
| cpu_rvalid | output | 1 | One-cycle pulse with read data |
| pad_in | input | NUM_PORTS*PORT_W | Pad input levels, port p at bits p*PORT_W upward |
| pad_oe | output | NUM_PORTS*PORT_W | Pad output enables |
| pad_out | output | NUM_PORTS*PORT_W | Pad output data |
| sleep | input | 1 | Sleep state, level |
| wake | output | 1 | Registered wake request |
| pwm_en | input | 1 | Hands the PWM pins to pwm_in |
| pwm_in | input | 2 | PWM waveforms |

## Verification
The bench uses the defaults: three ports of eight bits, wake on port 0, and PWM on bits 2 and 3 of port 2. With three ports, the two addresses of the fourth port index stay unused, so that path can be exercised. Eight-bit ports let one direction pattern split a port into input and output halves. Port 0 then carries both a masked and an unmasked wake bit, and port 2 places the PWM bits between plain latch bits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SET   = 3'd2,
    OP_CLR   = 3'd3,
    OP_CPL   = 3'd4
  } gpio_op_e;

  function automatic logic is_modify(input logic [2:0] op);
    return (op == OP_WRITE) || (op == OP_SET) || (op == OP_CLR) || (op == OP_CPL);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              dir_we,
  input  logic [PORT_W-1:0] wval,
  input  logic [PORT_W-1:0] pad_sync,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] view,
  output logic [PORT_W-1:0] oe,
  output logic [PORT_W-1:0] dout
);
  logic [PORT_W-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '1;
    end else begin
      if (data_we) latch_q <= wval;
      if (dir_we)  dir_q   <= wval;
    end
  end

  // inputs show the pad, outputs show the latch
  assign view = (dir_q & pad_sync) | (~dir_q & latch_q);
  assign oe   = ~dir_q;
  assign dout = latch_q;
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep,
  input  logic [W-1:0] pad_sync,
  input  logic [W-1:0] dir,
  output logic         wake
);
  logic [W-1:0] snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      wake <= 1'b0;
    end else begin
      if (!sleep) snap <= pad_sync;
      wake <= sleep && (|((pad_sync ^ snap) & dir));
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int WAKE_PORT = 0,
  parameter int PWM_PORT  = 2,
  parameter int PWM_LO    = 2,
  parameter int PWM_HI    = 3,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W   = PIDX_W + 1,
  localparam int BIT_W    = (PORT_W > 1) ? $clog2(PORT_W) : 1,
  localparam int TOT_W    = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic [2:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BIT_W-1:0]  cpu_bit,
  input  logic [PORT_W-1:0] cpu_wdata,
  output logic [PORT_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic [TOT_W-1:0]  pad_in,
  output logic [TOT_W-1:0]  pad_oe,
  output logic [TOT_W-1:0]  pad_out,
  input  logic              sleep,
  output logic              wake,
  input  logic              pwm_en,
  input  logic [1:0]        pwm_in
);
  logic [TOT_W-1:0]  pad_sync;
  logic [TOT_W-1:0]  dout_all;
  logic [PORT_W-1:0] dir_a  [NUM_PORTS];
  logic [PORT_W-1:0] view_a [NUM_PORTS];
  logic [NUM_PORTS-1:0] data_we, dir_we;

  logic [PIDX_W-1:0] sel_port;
  logic              sel_dir, in_range, do_mod;
  logic [PORT_W-1:0] cur, nxt, bit_mask;

  gpio_sync #(.W(TOT_W)) i_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pad_sync)
  );

  assign sel_port = cpu_addr[ADDR_W-1:1];
  assign sel_dir  = cpu_addr[0];
  assign in_range = ({1'b0, sel_port} < (PIDX_W+1)'(NUM_PORTS));
  assign do_mod   = cpu_en && in_range && is_modify(cpu_op);
  assign bit_mask = PORT_W'(1) << cpu_bit;

  always_comb begin
    cur = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (in_range && sel_port == PIDX_W'(p))
        cur = sel_dir ? dir_a[p] : view_a[p];
    end
  end

  always_comb begin
    case (cpu_op)
      OP_WRITE: nxt = cpu_wdata;
      OP_SET:   nxt = cur | bit_mask;
      OP_CLR:   nxt = cur & ~bit_mask;
      OP_CPL:   nxt = ~cur;
      default:  nxt = cur;
    endcase
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign data_we[p] = do_mod && (sel_port == PIDX_W'(p)) && !sel_dir;
    assign dir_we[p]  = do_mod && (sel_port == PIDX_W'(p)) && sel_dir;

    gpio_port_slice #(.PORT_W(PORT_W)) i_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_we  (data_we[p]),
      .dir_we   (dir_we[p]),
      .wval     (nxt),
      .pad_sync (pad_sync[p*PORT_W +: PORT_W]),
      .dir_q    (dir_a[p]),
      .view     (view_a[p]),
      .oe       (pad_oe[p*PORT_W +: PORT_W]),
      .dout     (dout_all[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    pad_out = dout_all;
    if (pwm_en) begin
      pad_out[PWM_PORT*PORT_W + PWM_LO] = pwm_in[0];
      pad_out[PWM_PORT*PORT_W + PWM_HI] = pwm_in[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_en && (cpu_op == OP_READ);
      if (cpu_en && cpu_op == OP_READ) cpu_rdata <= cur;
    end
  end

  gpio_wake #(.W(PORT_W)) i_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .pad_sync (pad_sync[WAKE_PORT*PORT_W +: PORT_W]),
    .dir      (dir_a[WAKE_PORT]),
    .wake     (wake)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int PWM_PORT  = 2,
  parameter int PWM_LO    = 2,
  parameter int PWM_HI    = 3,
  parameter int PIDX_W    = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cpu_en,
  input logic [2:0]                  cpu_op,
  input logic [PIDX_W-1:0]           sel_port,
  input logic                        cpu_rvalid,
  input logic                        sleep,
  input logic                        wake,
  input logic                        pwm_en,
  input logic [1:0]                  pwm_in,
  input logic [NUM_PORTS*PORT_W-1:0] pad_out,
  input logic [NUM_PORTS*PORT_W-1:0] pad_oe
);
  // R2
  oe_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |=> $stable(pad_oe));

  // R9
  range_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && ({1'b0, sel_port} >= (PIDX_W+1)'(NUM_PORTS))) |=> $stable(pad_oe));

  // R12
  rvalid_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_en && cpu_op == 3'd0));

  // R10
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(sleep));

  // R11
  pwm_pins_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> (pad_out[PWM_PORT*PORT_W + PWM_LO] == pwm_in[0] &&
                pad_out[PWM_PORT*PORT_W + PWM_HI] == pwm_in[1]));
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .PWM_PORT(PWM_PORT),
  .PWM_LO(PWM_LO), .PWM_HI(PWM_HI), .PIDX_W(PIDX_W)
) i_gpio_bank_chk (
  .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_op(cpu_op),
  .sel_port(cpu_addr[ADDR_W-1:1]), .cpu_rvalid(cpu_rvalid),
  .sleep(sleep), .wake(wake), .pwm_en(pwm_en), .pwm_in(pwm_in),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  localparam int NP = 3, PW = 8, TW = NP*PW;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, ST = 3'd2, CL = 3'd3, CP = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_en = 1'b0;
  logic [2:0] cpu_op = 3'd0;
  logic [2:0] cpu_addr = '0;
  logic [2:0] cpu_bit = '0;
  logic [PW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_rvalid;
  logic [TW-1:0] pad_in = '0, pad_oe, pad_out;
  logic sleep = 1'b0, wake, pwm_en = 1'b0;
  logic [1:0] pwm_in = 2'b00;
  int n_chk = 0, n_fail = 0;
  logic [PW-1:0] rd;

  always #4 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_bit(cpu_bit), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .sleep(sleep), .wake(wake),
    .pwm_en(pwm_en), .pwm_in(pwm_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic cmd(input logic [2:0] op, input logic [2:0] addr,
                     input logic [2:0] b, input logic [PW-1:0] wd);
    cpu_op = op; cpu_addr = addr; cpu_bit = b; cpu_wdata = wd; cpu_en = 1'b1;
    @(negedge clk);
    cpu_en = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] addr, output logic [PW-1:0] v);
    cmd(RD, addr, 3'd0, '0);
    v = cpu_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 oe", pad_oe, '0);
    for (int p = 0; p < NP; p++) begin
      rdreg(3'(2*p+1), rd);
      chk("R1 dir", rd, 8'hFF);
    end
    rdreg(3'd0, rd);
    chk("R1 input read", rd, 8'h00);
    cmd(WR, 3'd3, 3'd0, 8'h00);
    rdreg(3'd2, rd);
    chk("R1 latch ones", rd, 8'hFF);
    chk("R1 pad_out", pad_out[15:8], 8'hFF);
  endtask

  task automatic t_mix;
    cmd(WR, 3'd1, 3'd0, 8'hF0);
    cmd(WR, 3'd0, 3'd0, 8'h5A);
    pad_in[7:0] = 8'hC3;
    idle(3);
    chk("R2 oe", pad_oe[7:0], 8'h0F);
    rdreg(3'd0, rd);
    chk("R3 mixed read", rd, 8'hCA);
    chk("R4 pad_out latch", pad_out[7:0], 8'h5A);
    pad_in[7:0] = 8'h3C;
    idle(5);
    chk("R4 hold", pad_out[7:0], 8'h5A);
    cmd(WR, 3'd0, 3'd0, 8'h33);
    chk("R4 rewrite", pad_out[7:0], 8'h33);
  endtask

  task automatic t_sync;
    cmd(WR, 3'd3, 3'd0, 8'hFF);
    pad_in[15:8] = 8'h00;
    idle(3);
    pad_in[15:8] = 8'hA5;
    idle(1);
    rdreg(3'd2, rd);
    chk("R5 edge n+1 old", rd, 8'h00);
    rdreg(3'd2, rd);
    chk("R5 edge n+2 new", rd, 8'hA5);
  endtask

  task automatic t_setclr;
    cmd(WR, 3'd5, 3'd0, 8'h0F);
    cmd(WR, 3'd4, 3'd0, 8'h00);
    pad_in[23:16] = 8'h0A;
    idle(3);
    cmd(ST, 3'd4, 3'd6, '0);
    cmd(WR, 3'd5, 3'd0, 8'h00);
    chk("R6 set pulls pads", pad_out[23:16], 8'h4A);
    cmd(CL, 3'd4, 3'd3, '0);
    chk("R6 clear", pad_out[23:16], 8'h42);
  endtask

  task automatic t_cpl;
    cmd(CP, 3'd4, 3'd0, '0);
    rdreg(3'd4, rd);
    chk("R7 complement", rd, 8'hBD);
  endtask

  task automatic t_dir_rmw;
    cmd(CL, 3'd3, 3'd0, '0);
    chk("R8 dir clear", pad_oe[15:8], 8'h01);
    cmd(ST, 3'd3, 3'd0, '0);
    chk("R8 dir set", pad_oe[15:8], 8'h00);
    cmd(CP, 3'd3, 3'd0, '0);
    rdreg(3'd3, rd);
    chk("R8 dir complement", rd, 8'h00);
    chk("R8 oe", pad_oe[15:8], 8'hFF);
    rdreg(3'd2, rd);
    chk("R8 latch untouched", rd, 8'hFF);
  endtask

  task automatic t_range;
    logic [TW-1:0] oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    cmd(WR, 3'd6, 3'd0, 8'h00);
    cmd(WR, 3'd7, 3'd0, 8'h00);
    cmd(CP, 3'd7, 3'd0, '0);
    cmd(3'd5, 3'd1, 3'd0, 8'h00);
    cmd(3'd7, 3'd0, 3'd0, 8'h00);
    chk("R9 oe unchanged", pad_oe, oe0);
    chk("R9 out unchanged", pad_out, out0);
    rdreg(3'd1, rd);
    chk("R9 dir unchanged", rd, 8'hF0);
    rdreg(3'd6, rd);
    chk("R9 empty read", rd, 8'h00);
  endtask

  task automatic t_rvalid;
    rdreg(3'd4, rd);
    chk("R12 rvalid on read", cpu_rvalid, 1'b1);
    idle(1);
    chk("R12 rvalid one cycle", cpu_rvalid, 1'b0);
    chk("R12 rdata held", cpu_rdata, 8'hBD);
    cmd(WR, 3'd0, 3'd0, 8'h33);
    chk("R12 no rvalid on write", cpu_rvalid, 1'b0);
  endtask

  task automatic t_wake;
    pad_in[7:0] = 8'h00;
    idle(3);
    chk("R10 awake", wake, 1'b0);
    sleep = 1'b1;
    idle(3);
    chk("R10 asleep quiet", wake, 1'b0);
    pad_in[1] = 1'b1;
    idle(5);
    chk("R10 output bit masked", wake, 1'b0);
    pad_in[5] = 1'b1;
    idle(2);
    chk("R10 not yet", wake, 1'b0);
    idle(1);
    chk("R10 wake", wake, 1'b1);
    pad_in[5] = 1'b0;
    idle(4);
    chk("R10 back to snapshot", wake, 1'b0);
    pad_in[6] = 1'b1;
    idle(4);
    chk("R10 wake again", wake, 1'b1);
    sleep = 1'b0;
    idle(1);
    chk("R10 cleared on exit", wake, 1'b0);
    idle(2);
    sleep = 1'b1;
    idle(4);
    chk("R10 new snapshot", wake, 1'b0);
    sleep = 1'b0;
    idle(1);
  endtask

  task automatic t_pwm;
    pwm_en = 1'b1; pwm_in = 2'b01;
    idle(1);
    chk("R11 pwm 01", pad_out[23:16], 8'hB5);
    pwm_in = 2'b10;
    idle(1);
    chk("R11 pwm 10", pad_out[23:16], 8'hB9);
    rdreg(3'd4, rd);
    chk("R11 latch read", rd, 8'hBD);
    pwm_en = 1'b0;
    idle(1);
    chk("R11 released", pad_out[23:16], 8'hBD);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_mix;
    t_sync;
    t_setclr;
    t_cpl;
    t_dir_rmw;
    t_range;
    t_rvalid;
    t_wake;
    t_pwm;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule